// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one display line for an LCD panel interface. Every line runs through four phases in a fixed order: a line-clock (sync) pulse, a back porch, the active pixels and a front porch, after which the next line starts at once. State moves forward only on clock cycles where the pixel clock enable is high, so one enabled cycle is one pixel clock.

The lengths of the phases come from a single 32-bit timing word. Each porch and sync field holds its length minus one, and the pixel field holds the active width divided by sixteen, minus one. The block latches this word once per line, on the enabled cycle that starts the sync phase, so software may rewrite it at any time without harming the line in progress. A panel-type input raises the sync width and the back porch to at least two pixel clocks for passive (STN) panels. A one-cycle fetch request at the start of every line lets a DMA path begin prefetching that line. An end-of-line flag marks the last front-porch pixel, so a vertical timing block can count lines.

The state machine has four states. The field width is the value of the register field plus one. `PH_SYNC` goes to `PH_BACK` after the sync width. `PH_BACK` goes to `PH_ACTIVE` after the back porch. `PH_ACTIVE` goes to `PH_FRONT` after the active pixel count. `PH_FRONT` returns to `PH_SYNC` after the front porch, and this return is the line start. A `run` flag covers the time after reset: the block rests in `PH_SYNC` with its outputs inactive, and its first enabled cycle is treated as a line start.

Top module: `lcd_hline_gen`

## Requirements
- R1: The active phase lasts 16 × (P + 1) pixel clocks, where P is `cfg_word[7:2]`. P = 19 gives 320, and the range is 16 to 1024. Bits 1:0 of `cfg_word` have no effect.
- R2: The sync phase lasts S + 1 pixel clocks, where S is `cfg_word[15:8]`. During this phase `hsync` is at its active level.
- R3: The back porch directly follows the sync phase and lasts B + 1 pixel clocks, where B is `cfg_word[31:24]`. It ends where the active pixels begin.
- R4: The front porch directly follows the last active pixel and lasts F + 1 pixel clocks, where F is `cfg_word[23:16]`. The next sync phase follows it.
- R5: While `stn_mode` is 1, the sync phase and the back porch each last at least 2 pixel clocks. Longer programmed values are used unchanged.
- R6: `de` is 1 only during active pixels. During the active phase `pix_idx` counts 0 to N − 1, and in every other phase it is 0.
- R7: `fetch_req` is high for exactly one clock cycle, the cycle after the enabled edge that starts a line (its sync phase). It is low at all other times.
- R8: `eol` is 1 during the last front-porch pixel clock of each line and 0 at all other times.
- R9: `cfg_word` and `stn_mode` are sampled only at line start. A change in the middle of a line alters only the lines that start after it.
- R10: With `sync_inv` = 1, `hsync` is active low. With `sync_inv` = 0 it is active high. The inactive level is also driven while the block is in reset.
- R11: On cycles with `pix_en` = 0 no state and no output changes, apart from `fetch_req` falling.
- R12: A synchronous `rst` sets `de`, `pix_idx`, `fetch_req` and `eol` to 0 and puts `hsync` at its inactive level. The first enabled cycle after reset starts a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel clock enable, one pixel per high cycle |
| stn_mode | input | 1 | Passive panel: enforce minimum sync and back porch of 2 |
| sync_inv | input | 1 | 1 makes `hsync` active low |
| cfg_word | input | 32 | Timing word: [31:24] back porch−1, [23:16] front porch−1, [15:8] sync−1, [7:2] pixels/16−1, [1:0] unused |
| hsync | output | 1 | Line clock / horizontal sync |
| de | output | 1 | Data enable during active pixels |
| pix_idx | output | 10 | Index of the current active pixel |
| fetch_req | output | 1 | One-cycle line data fetch request |
| eol | output | 1 | Last front-porch pixel of the line |

## Verification
The hardest case to reach is a timing word that changes in the middle of a line. The register has to be written after the line has already latched its values, and the result has to show up in the line that follows and not in the current one. The bench rewrites `cfg_word` on the first active pixel of a measured line. It then checks that this line keeps its old widths and that the next line takes the new ones. The extreme words are also covered, reached by setting every field to 0 or to its maximum: a 1024-pixel line with 256-clock porches, and a 16-pixel line with one-clock phases that the STN clamp then lengthens.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

    localparam int PPL_W     = 6;
    localparam int FLD_W     = 8;
    localparam int GRAN_LOG2 = 4;
    localparam int STN_MIN   = 2;

    localparam int PPL_LSB   = 2;
    localparam int HSW_LSB   = PPL_LSB + PPL_W;
    localparam int HFP_LSB   = HSW_LSB + FLD_W;
    localparam int HBP_LSB   = HFP_LSB + FLD_W;
    localparam int CFG_W     = HBP_LSB + FLD_W;

    localparam int LEN_W     = FLD_W + 1;
    localparam int IDX_W     = PPL_W + GRAN_LOG2;
    localparam int CNT_W     = IDX_W + 1;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } lcdh_phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] act_len;
        logic [LEN_W-1:0] sync_len;
        logic [LEN_W-1:0] back_len;
        logic [LEN_W-1:0] front_len;
    } lcdh_len_t;

endpackage

// File: rtl/lcdh_cfg_unpack.sv
module lcdh_cfg_unpack
    import lcdh_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             stn_mode,
    output lcdh_len_t        len
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    function automatic logic [LEN_W-1:0] field_len(input logic [FLD_W-1:0] f,
                                                   input logic            floor_en);
        logic [LEN_W-1:0] v;
        v = {1'b0, f} + LEN_W'(1);
        if (floor_en && (v < LEN_W'(STN_MIN)))
            v = LEN_W'(STN_MIN);
        return v;
    endfunction

    logic [PPL_W-1:0] ppl_f;
    logic [FLD_W-1:0] hsw_f, hfp_f, hbp_f;

    always_comb begin
        ppl_f = cfg_word[PPL_LSB +: PPL_W];
        hsw_f = cfg_word[HSW_LSB +: FLD_W];
        hfp_f = cfg_word[HFP_LSB +: FLD_W];
        hbp_f = cfg_word[HBP_LSB +: FLD_W];
        len.act_len   = (CNT_W'(ppl_f) + CNT_ONE) << GRAN_LOG2;
        len.sync_len  = field_len(hsw_f, stn_mode);
        len.back_len  = field_len(hbp_f, stn_mode);
        len.front_len = field_len(hfp_f, 1'b0);
    end

endmodule

// File: rtl/lcdh_line_fsm.sv
module lcdh_line_fsm
    import lcdh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  lcdh_len_t        live_len,
    output logic             sync_act,
    output logic             de,
    output logic [IDX_W-1:0] pix_idx,
    output logic             fetch_req,
    output logic             eol
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lcdh_phase_e      ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cur_len;
    logic             run_q;
    lcdh_len_t        len_q;
    logic             line_start;

    always_comb begin
        unique case (ph_q)
            PH_SYNC:   cur_len = CNT_W'(len_q.sync_len);
            PH_BACK:   cur_len = CNT_W'(len_q.back_len);
            PH_ACTIVE: cur_len = len_q.act_len;
            PH_FRONT:  cur_len = CNT_W'(len_q.front_len);
        endcase
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q + CNT_ONE;
        if (!run_q) begin
            ph_d  = PH_SYNC;
            cnt_d = '0;
        end else if (cnt_q == cur_len - CNT_ONE) begin
            cnt_d = '0;
            unique case (ph_q)
                PH_SYNC:   ph_d = PH_BACK;
                PH_BACK:   ph_d = PH_ACTIVE;
                PH_ACTIVE: ph_d = PH_FRONT;
                PH_FRONT:  ph_d = PH_SYNC;
            endcase
        end
        line_start = pix_en && (ph_d == PH_SYNC) && (cnt_d == '0);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
            run_q <= 1'b0;
            len_q <= '0;
        end else if (pix_en) begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            run_q <= 1'b1;
            if (line_start)
                len_q <= live_len;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_act  <= 1'b0;
            de        <= 1'b0;
            pix_idx   <= '0;
            fetch_req <= 1'b0;
            eol       <= 1'b0;
        end else begin
            fetch_req <= line_start;
            if (pix_en) begin
                sync_act <= (ph_d == PH_SYNC);
                de       <= (ph_d == PH_ACTIVE);
                pix_idx  <= (ph_d == PH_ACTIVE) ? cnt_d[IDX_W-1:0] : '0;
                eol      <= (ph_d == PH_FRONT) &&
                            (cnt_d == CNT_W'(len_q.front_len) - CNT_ONE);
            end
        end
    end

    // R7
    fetch_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req);

    // R6
    de_sync_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(de && sync_act));

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(ph_q) && $stable(cnt_q) && $stable(pix_idx) && $stable(de));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && de && (ph_d == PH_ACTIVE)) |=> (pix_idx == $past(pix_idx) + IDX_W'(1)));

    // R8
    eol_in_front_chk: assert property (@(posedge clk) disable iff (rst)
        eol |-> (ph_q == PH_FRONT));

endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
    import lcdh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             stn_mode,
    input  logic             sync_inv,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             hsync,
    output logic             de,
    output logic [IDX_W-1:0] pix_idx,
    output logic             fetch_req,
    output logic             eol
);

    lcdh_len_t live_len;
    logic      sync_act;

    lcdh_cfg_unpack u_unpack (
        .cfg_word (cfg_word),
        .stn_mode (stn_mode),
        .len      (live_len)
    );

    lcdh_line_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .live_len  (live_len),
        .sync_act  (sync_act),
        .de        (de),
        .pix_idx   (pix_idx),
        .fetch_req (fetch_req),
        .eol       (eol)
    );

    assign hsync = sync_act ^ sync_inv;

    // R5
    stn_floor_chk: assert property (@(posedge clk) disable iff (rst)
        stn_mode |-> (live_len.sync_len >= LEN_W'(STN_MIN)) && (live_len.back_len >= LEN_W'(STN_MIN)));

endmodule

// File: tb/lcd_hline_gen_tb_top.sv
module lcd_hline_gen_tb_top;

    typedef struct packed {
        bit       stn;
        bit [1:0] rsv;
        bit [5:0] ppl;
        bit [7:0] hsw;
        bit [7:0] hfp;
        bit [7:0] hbp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b00, 6'd19, 8'd2,   8'd4,   8'd4},
        '{1'b0, 2'b00, 6'd0,  8'd0,   8'd0,   8'd0},
        '{1'b1, 2'b00, 6'd0,  8'd0,   8'd0,   8'd0},
        '{1'b1, 2'b00, 6'd1,  8'd5,   8'd1,   8'd3},
        '{1'b0, 2'b00, 6'd63, 8'd1,   8'd255, 8'd255},
        '{1'b1, 2'b11, 6'd2,  8'd255, 8'd0,   8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_en = 1'b0;
    logic        stn_mode = 1'b0;
    logic        sync_inv = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        hsync, de, fetch_req, eol;
    logic [9:0]  pix_idx;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lcd_hline_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .stn_mode  (stn_mode),
        .sync_inv  (sync_inv),
        .cfg_word  (cfg_word),
        .hsync     (hsync),
        .de        (de),
        .pix_idx   (pix_idx),
        .fetch_req (fetch_req),
        .eol       (eol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input vec_t v);
        return {v.hbp, v.hfp, v.hsw, v.ppl, v.rsv};
    endfunction

    function automatic int fld_len(input int f, input bit floor_en);
        return (floor_en && (f + 1 < 2)) ? 2 : f + 1;
    endfunction

    task automatic wait_fetch();
        do @(negedge clk); while (!fetch_req);
    endtask

    // entered at a negedge where a line start is shown
    task automatic measure(input vec_t v, input bit mid, input logic [31:0] mid_cfg,
                           input string tag);
        int s = 0, b = 0, a = 0, f = 0, ecnt = 0, xfetch = 0;
        bit idx_ok = 1'b1, eol_last = 1'b0;
        int es = fld_len(int'(v.hsw), v.stn);
        int eb = fld_len(int'(v.hbp), v.stn);
        int ea = 16 * (int'(v.ppl) + 1);
        int ef = int'(v.hfp) + 1;
        while (hsync == ~sync_inv && s < 2000) begin
            if (s > 0 && fetch_req) xfetch++;
            if (de || pix_idx != 0) idx_ok = 1'b0;
            if (eol) ecnt++;
            s++; @(negedge clk);
        end
        while (!de && b < 2000) begin
            if (fetch_req) xfetch++;
            if (pix_idx != 0) idx_ok = 1'b0;
            if (eol) ecnt++;
            b++; @(negedge clk);
        end
        while (de && a < 2000) begin
            if (mid && a == 0) cfg_word = mid_cfg;
            if (fetch_req) xfetch++;
            if (pix_idx != 10'(a)) idx_ok = 1'b0;
            if (eol) ecnt++;
            a++; @(negedge clk);
        end
        while (!fetch_req && f < 2000) begin
            if (pix_idx != 0) idx_ok = 1'b0;
            if (eol) ecnt++;
            eol_last = eol;
            f++; @(negedge clk);
        end
        chk(s == es, {tag, " R2/R5 sync width"}, s, es);
        chk(b == eb, {tag, " R3/R5 back porch"}, b, eb);
        chk(a == ea, {tag, " R1 active count"}, a, ea);
        chk(f == ef, {tag, " R4 front porch"}, f, ef);
        chk(idx_ok, {tag, " R6 pixel index"}, int'(idx_ok), 1);
        chk(ecnt == 1 && eol_last, {tag, " R8 eol pulses"}, ecnt, 1);
        chk(xfetch == 0, {tag, " R7 stray fetch"}, xfetch, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R7 line progress actual=stalled expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cfg_word = word_of(VEC[0]);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state with enable low
        chk(hsync == 1'b0 && de == 1'b0 && pix_idx == 0 && !fetch_req && !eol,
            "R12 reset outputs", int'({hsync, de, fetch_req, eol}), 0);
        sync_inv = 1'b1;
        #0.1;
        chk(hsync == 1'b1, "R10 inactive level inverted", int'(hsync), 1);
        sync_inv = 1'b0;

        // vector table walk
        pix_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            cfg_word = word_of(VEC[i]);
            stn_mode = VEC[i].stn;
            wait_fetch();
            wait_fetch();
            measure(VEC[i], 1'b0, '0, $sformatf("vec%0d", i));
        end

        // R10 active-low sync
        sync_inv = 1'b1;
        cfg_word = word_of(VEC[1]);
        stn_mode = 1'b0;
        wait_fetch();
        wait_fetch();
        chk(hsync == 1'b0, "R10 sync low when inverted", int'(hsync), 0);
        measure(VEC[1], 1'b0, '0, "inv");
        sync_inv = 1'b0;

        // R9 mid-line rewrite
        cfg_word = word_of(VEC[0]);
        wait_fetch();
        wait_fetch();
        measure(VEC[0], 1'b1, word_of(VEC[1]), "R9 old-line");
        measure(VEC[1], 1'b0, '0, "R9 next-line");

        // R11 enable gating
        cfg_word = word_of(VEC[0]);
        wait_fetch();
        wait_fetch();
        begin
            bit held = 1'b1;
            while (!(de && pix_idx == 10)) @(negedge clk);
            pix_en = 1'b0;
            repeat (7) begin
                @(negedge clk);
                if (!(de && pix_idx == 10 && !fetch_req && !eol)) held = 1'b0;
            end
            chk(held, "R11 hold while disabled", int'(pix_idx), 10);
            pix_en = 1'b1;
            @(negedge clk);
            chk(pix_idx == 11, "R11 resume", int'(pix_idx), 11);
        end

        // R12 reset in mid-line
        rst = 1'b1;
        @(negedge clk);
        chk(!de && pix_idx == 0 && !fetch_req && !eol && hsync == 1'b0,
            "R12 reset mid-line", int'({hsync, de, fetch_req, eol}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_req && hsync == 1'b1, "R12/R7 first tick starts line",
            int'({fetch_req, hsync}), 3);
        @(negedge clk);
        chk(!fetch_req, "R7 fetch one cycle", int'(fetch_req), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule